// File: doc/BRIEF.md
# Multi-channel countdown timer

This block holds four independent countdown channels that share one clock and one level interrupt line. Software sets each channel up through a simple synchronous register bus. It writes a 64-bit interval as two 32-bit words, picks a power-of-two prescaler, and chooses whether the channel stops after one expiry or reloads and runs again. The current 64-bit count can be read back at any time. Because the counter runs downward, a channel loaded with all ones and left free-running acts as a timestamp source.

Each channel has a pending flag that is set when its counter expires. Software clears a flag by writing 1 to its bit. The interrupt output is high while any channel is both pending and enabled. When a channel is disabled, it keeps counting for a short fixed window before it actually stops. Interval values below three are raised to three when loaded, so the shortest delay is always honoured.

Bus reads are combinational. `bus_rdata_o` is valid in the same cycle as `bus_req_i` with `bus_we_i` low, and reads zero at all other times.

Top module: `cdt_timer`

## Requirements
- R1: After reset every register reads zero, no channel runs and `irq_o` is low.
- R2: Register map, byte offsets on a 32-bit bus: interrupt enable at 0x00 (bit n for channel n) and pending flags at 0x04. Channel n has its control word at 0x10+0x20*n, its interval low and high words at +0x04 and +0x08, and its count low and high words at +0x0C and +0x10. The control word has enable at bit 0, reload at bit 1, prescaler select at bits [6:4] and one-shot at bit 7 (0 = periodic). Bits 3:2 and 31:8 read zero. The interrupt enable, interval and control words read back what was last written.
- R3: A control write with enable and reload both 1 loads the interval into the count and starts the channel. After that, the count falls by one on every channel tick.
- R4: A free-running 7-bit divider advances on every clock after reset. A channel with prescaler select p ticks on the clocks where the low p divider bits are all ones, so p = 0 ticks every clock and p = 7 ticks once every 128 clocks.
- R5: A tick that finds a running count at zero is an expiry. It sets the channel's pending bit, and in periodic mode it reloads the loaded interval value.
- R6: In one-shot mode an expiry stops the channel. The count stays at zero and the control enable bit reads back 0.
- R7: A control write with enable 0 to a running channel clears the enable bit at once. The counter still advances on the write edge and on the next two edges, and is frozen from then on.
- R8: An interval below 3 is loaded, and reloaded, as 3.
- R9: Writing 1 to a bit of 0x04 clears that pending bit and writing 0 leaves it. If an expiry and a clear land on the same edge, the bit ends set.
- R10: `irq_o` is high exactly when some channel has both its pending bit and its enable bit set.
- R11: Reads of unmapped or unaligned addresses return zero. Writes to them, and writes to the count words, change nothing.
- R12: A control write with enable 1 and reload 0 starts the channel from its current count without loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The stop-latency assertion assumes software never writes a second disable to a channel while its stop window is still open. The pending-bit assertions assume that clear writes target 0x04 only as whole-word writes. The stimulus issues exactly one disable per stop and waits well past the window before touching that channel's control word again. A behavioural model in the bench tracks the divider phase, every count, the stop windows and the pending flags, and compares `irq_o` and every read result on every cycle. It also hammers the clear register against a fast periodic channel, so that clears and expiries coincide.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  localparam int OFF_IEN   = 'h00;
  localparam int OFF_STS   = 'h04;
  localparam int CH_BASE   = 'h10;
  localparam logic [4:0] SUB_CTRL = 5'h00;
  localparam logic [4:0] SUB_ILO  = 5'h04;
  localparam logic [4:0] SUB_IHI  = 5'h08;
  localparam logic [4:0] SUB_CLO  = 5'h0C;
  localparam logic [4:0] SUB_CHI  = 5'h10;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_RL  = 1;
  localparam int CTRL_PSC = 4;
  localparam int CTRL_OS  = 7;
  localparam int PSC_W    = 3;
  localparam int DIV_W    = (1 << PSC_W) - 1;

  function automatic logic [7:0] pack_ctrl(input logic en, input logic rl,
                                           input logic [PSC_W-1:0] psc, input logic os);
    logic [7:0] w;
    w = '0;
    w[CTRL_EN] = en;
    w[CTRL_RL] = rl;
    w[CTRL_PSC +: PSC_W] = psc;
    w[CTRL_OS] = os;
    return w;
  endfunction
endpackage

// File: rtl/cdt_prediv.sv
`timescale 1ns/1ps
module cdt_prediv
  import cdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [DIV_W-1:0] div_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign div_o = div_q;
endmodule

// File: rtl/cdt_chan.sv
`timescale 1ns/1ps
module cdt_chan
  import cdt_pkg::*;
#(
  parameter int DW       = 32,
  parameter int MIN_LOAD = 3,
  parameter int STOP_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              ctrl_we_i,
  input  logic              ilo_we_i,
  input  logic              ihi_we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [7:0]        ctrl_o,
  output logic [2*DW-1:0]   ival_o,
  output logic [2*DW-1:0]   cnt_o,
  output logic              run_o,
  output logic              expire_o
);
  localparam int CNT_W  = 2 * DW;
  localparam int STOP_W = $clog2(STOP_LAT + 1);

  logic             en_q, rl_q, os_q, run_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] ival_q, cnt_q, load_val;
  logic [STOP_W-1:0] stop_q;
  logic [DIV_W-1:0] mask;
  logic             tick;

  logic             w_en, w_rl, w_os;
  logic [PSC_W-1:0] w_psc;

  assign w_en  = wdata_i[CTRL_EN];
  assign w_rl  = wdata_i[CTRL_RL];
  assign w_os  = wdata_i[CTRL_OS];
  assign w_psc = wdata_i[CTRL_PSC +: PSC_W];

  always_comb mask = DIV_W'((32'd1 << psc_q) - 32'd1);
  assign tick     = ((div_i & mask) == mask);
  assign load_val = (ival_q < CNT_W'(MIN_LOAD)) ? CNT_W'(MIN_LOAD) : ival_q;
  assign expire_o = run_q & tick & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      rl_q   <= 1'b0;
      os_q   <= 1'b0;
      psc_q  <= '0;
      run_q  <= 1'b0;
      stop_q <= '0;
      ival_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ilo_we_i) ival_q[DW-1:0]     <= wdata_i;
      if (ihi_we_i) ival_q[CNT_W-1:DW] <= wdata_i;

      if (run_q && tick) begin
        if (cnt_q == '0) begin
          if (os_q) begin
            run_q <= 1'b0;
            en_q  <= 1'b0;
          end else begin
            cnt_q <= load_val;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      // pending disable: channel keeps running until window closes
      if (stop_q != '0) begin
        stop_q <= stop_q - 1'b1;
        if (stop_q == STOP_W'(1)) run_q <= 1'b0;
      end

      if (ctrl_we_i) begin
        en_q  <= w_en;
        rl_q  <= w_rl;
        os_q  <= w_os;
        psc_q <= w_psc;
        if (w_en) begin
          run_q  <= 1'b1;
          stop_q <= '0;
          if (w_rl) cnt_q <= load_val;
        end else if (run_q && stop_q == '0) begin
          stop_q <= STOP_W'(STOP_LAT);
        end
      end
    end
  end

  assign ctrl_o = pack_ctrl(en_q, rl_q, psc_q, os_q);
  assign ival_o = ival_q;
  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
endmodule

// File: rtl/cdt_irq.sv
`timescale 1ns/1ps
module cdt_irq #(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ien_we_i,
  input  logic            sts_we_i,
  input  logic [N_CH-1:0] wdata_i,
  input  logic [N_CH-1:0] expire_i,
  output logic [N_CH-1:0] ien_o,
  output logic [N_CH-1:0] sts_o,
  output logic            irq_o
);
  logic [N_CH-1:0] ien_q, sts_q, clr;

  assign clr = sts_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      if (ien_we_i) ien_q <= wdata_i;
      sts_q <= (sts_q & ~clr) | expire_i;
    end
  end

  assign ien_o = ien_q;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ien_q);
endmodule

// File: rtl/cdt_timer.sv
`timescale 1ns/1ps
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DW;
  localparam int IDX_W = ADDR_W - 5;

  logic wr_en, rd_en, in_ch, ien_we, sts_we;
  logic [ADDR_W-1:0] off;
  logic [4:0]        sub;
  logic [IDX_W-1:0]  ch_idx;

  logic [DIV_W-1:0] div;
  logic [N_CH-1:0]  ctrl_we_v, ilo_we_v, ihi_we_v, run_v, exp_v, os_v, ien_v, sts_v;
  logic [N_CH-1:0][7:0]       ctrl_v;
  logic [N_CH-1:0][CNT_W-1:0] ival_v, cnt_v;

  assign wr_en  = bus_req_i & bus_we_i;
  assign rd_en  = bus_req_i & ~bus_we_i;
  assign off    = bus_addr_i - ADDR_W'(CH_BASE);
  assign sub    = off[4:0];
  assign ch_idx = off[ADDR_W-1:5];
  assign in_ch  = (bus_addr_i >= ADDR_W'(CH_BASE)) && (bus_addr_i[1:0] == 2'b00)
                  && (int'(ch_idx) < N_CH);
  assign ien_we = wr_en && (bus_addr_i == ADDR_W'(OFF_IEN));
  assign sts_we = wr_en && (bus_addr_i == ADDR_W'(OFF_STS));

  cdt_prediv u_prediv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_o (div)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic sel;
    assign sel          = wr_en && in_ch && (int'(ch_idx) == i);
    assign ctrl_we_v[i] = sel && (sub == SUB_CTRL);
    assign ilo_we_v[i]  = sel && (sub == SUB_ILO);
    assign ihi_we_v[i]  = sel && (sub == SUB_IHI);
    assign os_v[i]      = ctrl_v[i][CTRL_OS];

    cdt_chan #(.DW(DW)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .div_i    (div),
      .ctrl_we_i(ctrl_we_v[i]),
      .ilo_we_i (ilo_we_v[i]),
      .ihi_we_i (ihi_we_v[i]),
      .wdata_i  (bus_wdata_i),
      .ctrl_o   (ctrl_v[i]),
      .ival_o   (ival_v[i]),
      .cnt_o    (cnt_v[i]),
      .run_o    (run_v[i]),
      .expire_o (exp_v[i])
    );
  end

  cdt_irq #(.N_CH(N_CH)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ien_we_i(ien_we),
    .sts_we_i(sts_we),
    .wdata_i (bus_wdata_i[N_CH-1:0]),
    .expire_i(exp_v),
    .ien_o   (ien_v),
    .sts_o   (sts_v),
    .irq_o   (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      if (bus_addr_i == ADDR_W'(OFF_IEN)) begin
        bus_rdata_o = DW'(ien_v);
      end else if (bus_addr_i == ADDR_W'(OFF_STS)) begin
        bus_rdata_o = DW'(sts_v);
      end else if (in_ch) begin
        for (int i = 0; i < N_CH; i++) begin
          if (int'(ch_idx) == i) begin
            case (sub)
              SUB_CTRL: bus_rdata_o = DW'(ctrl_v[i]);
              SUB_ILO:  bus_rdata_o = ival_v[i][DW-1:0];
              SUB_IHI:  bus_rdata_o = ival_v[i][CNT_W-1:DW];
              SUB_CLO:  bus_rdata_o = cnt_v[i][DW-1:0];
              SUB_CHI:  bus_rdata_o = cnt_v[i][CNT_W-1:DW];
              default:  bus_rdata_o = '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/cdt_timer_chk.sv
`timescale 1ns/1ps
module cdt_timer_chk #(
  parameter int N_CH  = 4,
  parameter int CNT_W = 64
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        irq_o,
  input logic [N_CH-1:0]             ien_v,
  input logic [N_CH-1:0]             sts_v,
  input logic [N_CH-1:0]             run_v,
  input logic [N_CH-1:0]             exp_v,
  input logic [N_CH-1:0]             os_v,
  input logic [N_CH-1:0]             ctrl_we_v,
  input logic [N_CH-1:0]             clr_v,
  input logic                        sts_we,
  input logic                        w_en,
  input logic                        w_rl,
  input logic [N_CH-1:0][CNT_W-1:0]  cnt_v
);
  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    a_r5_expire_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exp_v[i] |=> sts_v[i]);

    a_r9_pending_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_v[i] && !(sts_we && clr_v[i])) |=> sts_v[i]);

    a_r9_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_we && clr_v[i] && !exp_v[i]) |=> !sts_v[i]);

    a_r8_min_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_we_v[i] && w_en && w_rl) |=> (cnt_v[i] >= CNT_W'(3)));

    a_r6_oneshot_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exp_v[i] && os_v[i] && !ctrl_we_v[i]) |=> !run_v[i]);

    a_r7_no_instant_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_v[i]) |-> ($past(exp_v[i]) || !$past(ctrl_we_v[i])));

    a_r10_irq_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exp_v[i] && ien_v[i]) |=> (irq_o || !ien_v[i]));

    a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_v[i] && !ctrl_we_v[i] && cnt_v[i] != '0) |=>
      (cnt_v[i] == $past(cnt_v[i]) || cnt_v[i] == $past(cnt_v[i]) - 1'b1));
  end
endmodule

bind cdt_timer cdt_timer_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .ien_v    (ien_v),
  .sts_v    (sts_v),
  .run_v    (run_v),
  .exp_v    (exp_v),
  .os_v     (os_v),
  .ctrl_we_v(ctrl_we_v),
  .clr_v    (bus_wdata_i[N_CH-1:0]),
  .sts_we   (sts_we),
  .w_en     (bus_wdata_i[0]),
  .w_rl     (bus_wdata_i[1]),
  .cnt_v    (cnt_v)
);

// File: tb/cdt_timer_bench.sv
`timescale 1ns/1ps
module cdt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  cdt_timer u_cdt_timer (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit [63:0] m_ival[4], m_cnt[4];
  bit        m_en[4], m_rl[4], m_os[4], m_run[4];
  bit [2:0]  m_psc[4];
  int        m_stop[4];
  bit [3:0]  m_ien, m_sts;
  int        m_div;

  function automatic bit decode(input bit [7:0] a, output int c, output int s);
    c = 0; s = 0;
    if (a < 16 || a[1:0] != 0) return 0;
    c = (int'(a) - 16) / 32;
    s = (int'(a) - 16) % 32;
    return c < 4;
  endfunction

  function automatic bit [31:0] m_read(input bit [7:0] a);
    int c, s;
    if (a == 8'h00) return {28'b0, m_ien};
    if (a == 8'h04) return {28'b0, m_sts};
    if (!decode(a, c, s)) return 0;
    case (s)
      0:  return {24'b0, m_os[c], m_psc[c], 2'b00, m_rl[c], m_en[c]};
      4:  return m_ival[c][31:0];
      8:  return m_ival[c][63:32];
      12: return m_cnt[c][31:0];
      16: return m_cnt[c][63:32];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_ival[c] = 0; m_cnt[c] = 0; m_en[c] = 0; m_rl[c] = 0; m_os[c] = 0;
        m_run[c] = 0; m_psc[c] = 0; m_stop[c] = 0;
      end
      m_ien = 0; m_sts = 0; m_div = 0;
    end else begin
      bit [3:0] ex;
      int wc, ws;
      bit wmap;
      ex = 0;
      wmap = decode(addr, wc, ws);
      for (int c = 0; c < 4; c++) begin
        bit [63:0] ld;
        bit run0;
        int stop0, mask;
        run0 = m_run[c]; stop0 = m_stop[c];
        ld = (m_ival[c] < 3) ? 64'd3 : m_ival[c];
        mask = (1 << m_psc[c]) - 1;
        if (m_run[c] && ((m_div & mask) == mask)) begin
          if (m_cnt[c] == 0) begin
            ex[c] = 1;
            if (m_os[c]) begin m_run[c] = 0; m_en[c] = 0; end
            else m_cnt[c] = ld;
          end else m_cnt[c] = m_cnt[c] - 1;
        end
        if (m_stop[c] > 0) begin
          m_stop[c]--;
          if (m_stop[c] == 0) m_run[c] = 0;
        end
        if (req && we && wmap && wc == c) begin
          if (ws == 0) begin
            m_en[c] = wdata[0]; m_rl[c] = wdata[1]; m_psc[c] = wdata[6:4]; m_os[c] = wdata[7];
            if (wdata[0]) begin
              m_run[c] = 1; m_stop[c] = 0;
              if (wdata[1]) m_cnt[c] = ld;
            end else if (run0 && stop0 == 0) m_stop[c] = 2;
          end
          if (ws == 4) m_ival[c][31:0]  = wdata;
          if (ws == 8) m_ival[c][63:32] = wdata;
        end
      end
      if (req && we && addr == 8'h04) m_sts = m_sts & ~wdata[3:0];
      m_sts = m_sts | ex;
      if (req && we && addr == 8'h00) m_ien = wdata[3:0];
      m_div = (m_div + 1) % 128;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_irq;
      exp_irq = |(m_sts & m_ien);
      vectors++;
      if (irq !== exp_irq) begin
        miscompares++;
        $display("FAIL %s irq_o t=%0t actual=%0b expected=%0b", phase, $time, irq, exp_irq);
      end
      if (req && !we) begin
        vectors++;
        if (rdata !== m_read(addr)) begin
          miscompares++;
          $display("FAIL %s read @%02h t=%0t actual=%08h expected=%08h",
                   phase, addr, $time, rdata, m_read(addr));
        end
      end
    end
  end

  task automatic drive(input logic r, input logic w, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    req = r; we = w; addr = a; wdata = d;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); drive(1, 1, a, d); endtask
  task automatic rd(input logic [7:0] a); drive(1, 0, a, 0); endtask
  task automatic rdn(input logic [7:0] a, input int n);
    for (int k = 0; k < n; k++) rd(a);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;

    phase = "R1";
    for (int a = 0; a < 'hA0; a += 4) rd(8'(a));
    rd(8'hFC);

    phase = "R2";
    wr(8'h00, 32'hF); rd(8'h00);
    wr(8'h14, 10); wr(8'h18, 0); wr(8'h34, 5); wr(8'h54, 4);
    wr(8'h74, 1); wr(8'h78, 32'h0000_0001);
    rd(8'h14); rd(8'h34); rd(8'h54); rd(8'h74); rd(8'h78);
    wr(8'h10, 32'h32); rd(8'h10);

    phase = "R3";
    wr(8'h10, 32'h03); rdn(8'h1C, 8);
    phase = "R5";
    rdn(8'h1C, 12); rd(8'h04);
    phase = "R10";
    rd(8'h00);
    phase = "R9";
    wr(8'h04, 32'h1); rd(8'h04);

    phase = "R4";
    wr(8'h30, 32'h23); rdn(8'h3C, 40);

    phase = "R6";
    wr(8'h50, 32'h83); rdn(8'h5C, 10); rdn(8'h50, 3); rd(8'h04);
    wr(8'h54, 3); wr(8'h50, 32'hF3); rdn(8'h5C, 600); rd(8'h50);

    phase = "R7";
    wr(8'h10, 32'h00); rdn(8'h1C, 6); rd(8'h10);
    wr(8'h30, 32'h20); rdn(8'h3C, 10);

    phase = "R12";
    wr(8'h10, 32'h01); rdn(8'h1C, 5);
    wr(8'h10, 32'h00); rdn(8'h1C, 5);

    phase = "R8";
    wr(8'h78, 0); wr(8'h74, 1); wr(8'h70, 32'h03); rdn(8'h7C, 6);
    wr(8'h74, 0); wr(8'h70, 32'h03); rdn(8'h7C, 10);
    phase = "R2";
    wr(8'h78, 2); wr(8'h70, 32'h03); rd(8'h80); rdn(8'h7C, 3); rd(8'h80);
    wr(8'h70, 32'h00); rdn(8'h7C, 5);

    phase = "R11";
    wr(8'h14, 0); wr(8'h10, 32'h03);
    wr(8'h1C, 32'hDEAD); rd(8'h1C); wr(8'h20, 5); rd(8'h20);
    wr(8'h11, 32'hFF); rd(8'h10); rd(8'h12);
    wr(8'h01, 32'h0); rd(8'h00); rd(8'h01);
    wr(8'h90, 32'h1); rd(8'h90); rd(8'h84); rd(8'hF0);

    phase = "R9";
    for (int k = 0; k < 16; k++) begin wr(8'h04, 32'hF); rd(8'h04); end
    phase = "R10";
    wr(8'h00, 32'h0); rdn(8'h04, 4);
    wr(8'h00, 32'h1); rdn(8'h04, 4);
    wr(8'h10, 32'h00); drive(0, 0, 0, 0);
    repeat (4) @(posedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired in phase %s actual=hung expected=finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule